// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes an incoming Ethernet frame as a byte stream with first-byte and last-byte markers and stores it in a circular buffer in local memory. The buffer is divided into 256-byte pages. The ring covers the pages from a start page up to, but not including, a stop page. A boundary page, owned by the host, marks how far the host has read. A current page marks where the next frame goes.

When the first byte of a frame arrives, the block checks that the controller is running and that the ring can hold a maximum-size frame. If both hold, the payload is written one byte per clock, starting four bytes into the current page. The write address wraps from the stop page back to the start page. Frames shorter than the minimum size are padded with zeros. A four-byte header is then written at the start of the page. The header holds the receive status, the page where the following frame will start, and the stored length. The current page then moves to that next page and a one-cycle done pulse is raised. A refused frame is consumed from the stream without touching memory.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the current page reads 0, the memory write strobe and the done pulse are low, and the stream ready is high.
- R2: A configuration write with select 0 loads the start page, 1 the stop page, 2 the boundary page and 3 the current page. The current page is visible on `cur_page` from the cycle after the write.
- R3: A frame is refused when `rx_stopped` is high, or when the free space is below 1518 bytes. Free space is computed with page addresses (page times 256). If current is below boundary, it is boundary minus current. Otherwise it is the ring size minus (current minus boundary). A refused frame causes no memory write and no done pulse, and it leaves the current page unchanged.
- R4: The bytes of an accepted frame are written in order, starting at current page times 256 plus 4. Each accepted byte appears on the memory port in the cycle after its handshake.
- R5: When a payload write address would reach stop page times 256, it continues at start page times 256.
- R6: A frame of fewer than 60 bytes is followed by zero bytes until 60 bytes are stored. One zero is written per clock.
- R7: The header occupies the first four bytes of the current page. It holds, in order: the status byte, the next page, the low byte of the stored length plus 4, and the high byte of that value.
- R8: Bit 0 of the status byte is always 1. Bit 5 equals bit 0 of the first frame byte (the group bit).
- R9: The next page is the current page plus ceil((stored length + 8) / 256). If the result is at or above the stop page, the ring size in pages is subtracted.
- R10: The done pulse lasts one cycle. It is high in the same cycle that the last header byte is on the memory port. From that cycle on, the current page holds the next page. The current page changes for no other reason than this or a configuration write.
- R11: `s_ready` is low while padding or header bytes are being written. It is 4 + (60 − length) cycles after the last-byte handshake for short frames, and 4 cycles for frames of 60 bytes or more, that the done pulse appears.
- R12: A byte offered while idle without the first-byte marker is discarded and causes no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_stopped | input | 1 | Controller stopped; new frames are refused |
| cfg_we | input | 1 | Pointer register write strobe |
| cfg_sel | input | 2 | Register select: 0 start, 1 stop, 2 boundary, 3 current |
| cfg_wdata | input | PTR_W | Page value to write |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_sof | input | 1 | Byte is the first of a frame |
| s_eof | input | 1 | Byte is the last of a frame |
| s_ready | output | 1 | Block can take a stream byte |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | PTR_W+PAGE_BITS | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| cur_page | output | PTR_W | Current page pointer |
| rx_done | output | 1 | One-cycle pulse when a frame is fully stored |

## Verification
Each payload byte is due on the memory port one cycle after its handshake. Padding bytes follow one per cycle. The four header bytes come next, and the done pulse and the new current page appear together with the last of them. The done pulse is therefore due 4 + pad cycles after the last-byte handshake. The bench drives inputs and samples outputs on falling edges and time-stamps both events with a cycle counter. It records memory writes as they appear on the port, compares the measured delay with the computed one, and checks the header, payload, padding and pointer against values that bench functions derive from the requirements. Refused and stray bytes are checked over a fixed idle window: no write strobe and no done pulse may appear in that window.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BODY,
    ST_PAD,
    ST_HDR,
    ST_DROP
  } rxr_state_e;

  // status byte bit positions (decoded by the host driver)
  localparam int STAT_OK_BIT  = 0;
  localparam int STAT_GRP_BIT = 5;

  // configuration select codes
  localparam logic [1:0] SEL_START = 2'd0;
  localparam logic [1:0] SEL_STOP  = 2'd1;
  localparam logic [1:0] SEL_BND   = 2'd2;
  localparam logic [1:0] SEL_CUR   = 2'd3;
endpackage

// File: rtl/rxr_ptr_regs.sv
module rxr_ptr_regs
  import rxr_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [PTR_W-1:0] cfg_wdata,
  input  logic             adv_en,
  input  logic [PTR_W-1:0] adv_page,
  output logic [PTR_W-1:0] start_pg,
  output logic [PTR_W-1:0] stop_pg,
  output logic [PTR_W-1:0] bnd_pg,
  output logic [PTR_W-1:0] cur_pg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_pg <= '0;
      stop_pg  <= '0;
      bnd_pg   <= '0;
      cur_pg   <= '0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          SEL_START: start_pg <= cfg_wdata;
          SEL_STOP:  stop_pg  <= cfg_wdata;
          SEL_BND:   bnd_pg   <= cfg_wdata;
          default:   cur_pg   <= cfg_wdata;
        endcase
      end
      // the frame commit takes priority over a host write to current
      if (adv_en) cur_pg <= adv_page;
    end
  end
endmodule

// File: rtl/rxr_space_gate.sv
module rxr_space_gate #(
  parameter int PTR_W     = 8,
  parameter int PAGE_BITS = 8,
  parameter int MAX_FRAME = 1518
) (
  input  logic             stopped,
  input  logic [PTR_W-1:0] start_pg,
  input  logic [PTR_W-1:0] stop_pg,
  input  logic [PTR_W-1:0] bnd_pg,
  input  logic [PTR_W-1:0] cur_pg,
  output logic             accept
);
  localparam int W = PTR_W + PAGE_BITS + 2;

  function automatic logic signed [W-1:0] byte_addr(input logic [PTR_W-1:0] pg);
    return $signed({2'b00, pg, {PAGE_BITS{1'b0}}});
  endfunction

  // bytes left between the write point and the host read point
  function automatic logic signed [W-1:0] room(input logic [PTR_W-1:0] lo, hi, bnd, cur);
    logic signed [W-1:0] c, b, ring;
    c    = byte_addr(cur);
    b    = byte_addr(bnd);
    ring = byte_addr(hi) - byte_addr(lo);
    if (c < b) return b - c;
    return ring - (c - b);
  endfunction

  logic signed [W-1:0] free_bytes;
  assign free_bytes = room(start_pg, stop_pg, bnd_pg, cur_pg);
  assign accept     = !stopped && (free_bytes >= $signed(W'(MAX_FRAME)));
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int PTR_W     = 8,
  parameter int PAGE_BITS = 8,
  parameter int MAX_FRAME = 1518,
  parameter int MIN_FRAME = 60,
  parameter int HDR_BYTES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_stopped,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_sel,
  input  logic [PTR_W-1:0]           cfg_wdata,
  input  logic                       s_valid,
  input  logic [7:0]                 s_data,
  input  logic                       s_sof,
  input  logic                       s_eof,
  output logic                       s_ready,
  output logic                       mem_we,
  output logic [PTR_W+PAGE_BITS-1:0] mem_addr,
  output logic [7:0]                 mem_wdata,
  output logic [PTR_W-1:0]           cur_page,
  output logic                       rx_done
);
  localparam int ADDR_W     = PTR_W + PAGE_BITS;
  localparam int PAGE_BYTES = 1 << PAGE_BITS;
  localparam int CNT_W      = 16;   // two-byte length field
  localparam int HIDX_W     = $clog2(HDR_BYTES);

  rxr_state_e          state;
  logic [CNT_W-1:0]    cnt;
  logic [ADDR_W-1:0]   wr_ptr;
  logic [HIDX_W-1:0]   hidx;
  logic                grp;
  logic [PTR_W-1:0]    start_pg, stop_pg, bnd_pg;
  logic                accept;

  // address arithmetic -------------------------------------------------
  function automatic logic [ADDR_W-1:0] ring_step(input logic [ADDR_W-1:0] a, lo, hi);
    logic [ADDR_W-1:0] n;
    n = a + 1'b1;
    return (n == hi) ? lo : n;
  endfunction

  function automatic logic [PTR_W-1:0] next_page(input logic [PTR_W-1:0] c, lo, hi,
                                                 input logic [CNT_W-1:0] tot);
    logic [CNT_W:0]   span;
    logic [PTR_W+1:0] n;
    span = {1'b0, tot} + (CNT_W+1)'(HDR_BYTES + PAGE_BYTES - 1);
    n    = {2'b00, c} + (PTR_W+2)'(span >> PAGE_BITS);
    if (n >= {2'b00, hi}) n = n - ({2'b00, hi} - {2'b00, lo});
    return n[PTR_W-1:0];
  endfunction

  function automatic logic [7:0] status_byte(input logic g);
    logic [7:0] s;
    s = '0;
    s[STAT_OK_BIT]  = 1'b1;
    s[STAT_GRP_BIT] = g;
    return s;
  endfunction

  // named events -------------------------------------------------------
  logic [ADDR_W-1:0] cur_a, start_a, stop_a;
  logic              hs, frame_open, in_pad, in_hdr, in_drop, hdr_last;
  logic [CNT_W-1:0]  cnt_nx, stored_len;
  logic [PTR_W-1:0]  nxt_pg;
  logic [7:0]        hdr_byte;

  assign cur_a      = {cur_page, {PAGE_BITS{1'b0}}};
  assign start_a    = {start_pg, {PAGE_BITS{1'b0}}};
  assign stop_a     = {stop_pg,  {PAGE_BITS{1'b0}}};
  assign s_ready    = (state == ST_IDLE) || (state == ST_BODY) || (state == ST_DROP);
  assign hs         = s_valid && s_ready;
  assign frame_open = (state == ST_IDLE) && hs && s_sof;
  assign in_pad     = (state == ST_PAD);
  assign in_hdr     = (state == ST_HDR);
  assign in_drop    = (state == ST_DROP);
  assign hdr_last   = in_hdr && (hidx == HIDX_W'(HDR_BYTES - 1));
  assign cnt_nx     = cnt + 1'b1;
  assign stored_len = cnt + CNT_W'(HDR_BYTES);
  assign nxt_pg     = next_page(cur_page, start_pg, stop_pg, stored_len);

  always_comb begin
    case (hidx)
      HIDX_W'(0): hdr_byte = status_byte(grp);
      HIDX_W'(1): hdr_byte = 8'(nxt_pg);
      HIDX_W'(2): hdr_byte = stored_len[7:0];
      default:    hdr_byte = stored_len[15:8];
    endcase
  end

  rxr_ptr_regs #(.PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .adv_en(hdr_last), .adv_page(nxt_pg),
    .start_pg(start_pg), .stop_pg(stop_pg), .bnd_pg(bnd_pg), .cur_pg(cur_page)
  );

  rxr_space_gate #(.PTR_W(PTR_W), .PAGE_BITS(PAGE_BITS), .MAX_FRAME(MAX_FRAME)) u_gate (
    .stopped(rx_stopped), .start_pg(start_pg), .stop_pg(stop_pg),
    .bnd_pg(bnd_pg), .cur_pg(cur_page), .accept(accept)
  );

  // frame sequencer ----------------------------------------------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      wr_ptr    <= '0;
      hidx      <= '0;
      grp       <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rx_done   <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      rx_done <= 1'b0;
      case (state)
        ST_IDLE: if (frame_open) begin
          if (accept) begin
            mem_we    <= 1'b1;
            mem_addr  <= cur_a + ADDR_W'(HDR_BYTES);
            mem_wdata <= s_data;
            wr_ptr    <= ring_step(cur_a + ADDR_W'(HDR_BYTES), start_a, stop_a);
            cnt       <= CNT_W'(1);
            grp       <= s_data[0];
            hidx      <= '0;
            if (s_eof) state <= (1 < MIN_FRAME) ? ST_PAD : ST_HDR;
            else       state <= ST_BODY;
          end else if (!s_eof) begin
            state <= ST_DROP;
          end
        end
        ST_BODY: if (hs) begin
          mem_we    <= 1'b1;
          mem_addr  <= wr_ptr;
          mem_wdata <= s_data;
          wr_ptr    <= ring_step(wr_ptr, start_a, stop_a);
          cnt       <= cnt_nx;
          if (s_eof) state <= (cnt_nx < CNT_W'(MIN_FRAME)) ? ST_PAD : ST_HDR;
        end
        ST_PAD: begin
          mem_we    <= 1'b1;
          mem_addr  <= wr_ptr;
          mem_wdata <= 8'h00;
          wr_ptr    <= ring_step(wr_ptr, start_a, stop_a);
          cnt       <= cnt_nx;
          if (cnt_nx >= CNT_W'(MIN_FRAME)) state <= ST_HDR;
        end
        ST_HDR: begin
          mem_we    <= 1'b1;
          mem_addr  <= cur_a + ADDR_W'(hidx);
          mem_wdata <= hdr_byte;
          hidx      <= hidx + 1'b1;
          if (hdr_last) begin
            rx_done <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        ST_DROP: if (hs && s_eof) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // checks -------------------------------------------------------------
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R10
  cur_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cur_page) && !$past(cfg_we)) |-> rx_done);

  // R6
  pad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_pad |=> (mem_we && mem_wdata == 8'h00));

  // R3
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_drop |=> !mem_we);

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (stop_pg != start_pg)) |-> (mem_addr != stop_a));
endmodule

// File: tb/sim_rx_ring_writer.sv
`timescale 1ns/1ps
module sim_rx_ring_writer;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_stopped = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        s_valid = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_sof = 1'b0;
  logic        s_eof = 1'b0;
  logic        s_ready, mem_we, rx_done;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, cur_page;

  rx_ring_writer u0 (
    .clk(clk), .rst_n(rst_n), .rx_stopped(rx_stopped),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .s_valid(s_valid), .s_data(s_data), .s_sof(s_sof), .s_eof(s_eof), .s_ready(s_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cur_page(cur_page), .rx_done(rx_done)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, wr_count = 0, done_cnt = 0, done_cyc = 0, eof_cyc = 0;
  logic [7:0] bmem [int];
  logic [7:0] frm [0:1599];
  int b_start, b_stop, b_bnd, b_cur;

  always @(posedge clk) cyc <= cyc + 1;

  // port monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (mem_we) begin
      bmem[int'(mem_addr)] = mem_wdata;
      wr_count++;
    end
    if (rx_done) begin
      done_cnt++;
      done_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    chk(1'b0, "watchdog", cyc, 0);
    summary();
    $finish;
  end

  function automatic logic [7:0] rd(input int a);
    if (bmem.exists(a)) return bmem[a];
    return 8'hxx;
  endfunction

  // R3: space rule restated in plain integers
  function automatic bit room_ok(input int st, sp, bn, cu, input bit stopped);
    int ca = cu * 256, ba = bn * 256, fr;
    fr = (ca < ba) ? (ba - ca) : ((sp - st) * 256 - (ca - ba));
    return !stopped && fr >= 1518;
  endfunction

  // R9
  function automatic int exp_next(input int cu, st, sp, len);
    int stored = ((len < 60) ? 60 : len) + 4;
    int n = cu + (stored + 4 + 255) / 256;
    if (n >= sp) n = n - (sp - st);
    return n;
  endfunction

  task automatic cfg(input logic [1:0] sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 8'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: b_start = val;
      2'd1: b_stop = val;
      2'd2: b_bnd = val;
      default: b_cur = val;
    endcase
  endtask

  task automatic drive_frame(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = frm[i]; s_sof = (i == 0); s_eof = (i == len - 1);
      while (!s_ready) @(negedge clk);
      @(posedge clk);
      #1;
      if (i == len - 1) eof_cyc = cyc;
    end
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
  endtask

  task automatic fill(input int len, input bit grp);
    for (int i = 0; i < len; i++) frm[i] = 8'($urandom);
    frm[0][0] = grp;
  endtask

  task automatic run_frame(input int len);
    bit ok = room_ok(b_start, b_stop, b_bnd, b_cur, rx_stopped);
    int w0 = wr_count, d0 = done_cnt, c0 = b_cur;
    int nxt = exp_next(b_cur, b_start, b_stop, len);
    int pad = (len < 60) ? 60 - len : 0;
    int stored = len + pad + 4;
    drive_frame(len);
    if (ok) begin
      int bad = 0, first_bad = -1;
      int a;
      logic [7:0] st;
      for (int t = 0; t < 400 && done_cnt == d0; t++) @(negedge clk);
      chk(done_cnt == d0 + 1, "R10 done pulse", done_cnt - d0, 1);
      chk(done_cyc - eof_cyc == 4 + pad, "R11 done latency", done_cyc - eof_cyc, 4 + pad);
      chk(int'(cur_page) == nxt, "R9 next page / R10 commit", cur_page, nxt);
      chk(wr_count - w0 == stored, "R6 write count", wr_count - w0, stored);
      st = 8'h01 | (frm[0][0] ? 8'h20 : 8'h00);
      chk(rd(c0 * 256) === st, "R8 status byte", rd(c0 * 256), st);
      chk(rd(c0 * 256 + 1) === 8'(nxt), "R7 header next", rd(c0 * 256 + 1), nxt);
      chk({rd(c0 * 256 + 3), rd(c0 * 256 + 2)} === 16'(stored), "R7 header length",
          {rd(c0 * 256 + 3), rd(c0 * 256 + 2)}, stored);
      a = c0 * 256 + 4;
      for (int i = 0; i < len + pad; i++) begin
        logic [7:0] e = (i < len) ? frm[i] : 8'h00;
        if (rd(a) !== e) begin
          bad++;
          if (first_bad < 0) first_bad = i;
        end
        a++;
        if (a == b_stop * 256) a = b_start * 256;
      end
      chk(bad == 0, "R4 R5 R6 payload", first_bad, -1);
      b_cur = nxt;
    end else begin
      repeat (12) @(negedge clk);
      chk(wr_count == w0, "R3 refused writes", wr_count - w0, 0);
      chk(done_cnt == d0, "R3 refused done", done_cnt - d0, 0);
      chk(int'(cur_page) == c0, "R3 refused pointer", cur_page, c0);
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    b_start = 0; b_stop = 0; b_bnd = 0; b_cur = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(cur_page == 8'h00, "R1 cur_page", cur_page, 0);
    chk(!mem_we && !rx_done, "R1 strobes", {mem_we, rx_done}, 0);
    chk(s_ready, "R1 ready", s_ready, 1);

    // R2
    cfg(2'd0, 'h40);
    cfg(2'd1, 'h50);
    cfg(2'd2, 'h40);
    cfg(2'd3, 'h40);
    chk(cur_page == 8'h40, "R2 current load", cur_page, 'h40);

    // R12: stray byte with no first-byte marker
    begin
      int w0 = wr_count;
      @(negedge clk);
      s_valid = 1'b1; s_data = 8'hA5; s_sof = 1'b0; s_eof = 1'b0;
      @(negedge clk);
      s_valid = 1'b0;
      repeat (8) @(negedge clk);
      chk(wr_count == w0, "R12 stray byte", wr_count - w0, 0);
    end

    // directed frames
    fill(20, 1'b0); run_frame(20);         // R6 short frame
    fill(60, 1'b1); run_frame(60);         // R8 group bit, exact minimum
    fill(1, 1'b1);  run_frame(1);          // single byte
    fill(300, 1'b0); run_frame(300);       // R4 multi-page

    // R5 wrap through stop page
    cfg(2'd3, 'h4E);
    cfg(2'd2, 'h4A);
    fill(600, 1'b0); run_frame(600);
    chk(b_cur == 'h41, "R5 wrapped next page", b_cur, 'h41);

    // R3 space limit, one page either side
    cfg(2'd3, 'h45); cfg(2'd2, 'h4A);
    fill(40, 1'b0); run_frame(40);          // 1280 bytes free: refused
    cfg(2'd3, 'h44);
    fill(40, 1'b0); run_frame(40);          // 1536 bytes free: accepted

    // R3 stopped controller
    cfg(2'd2, b_cur);
    rx_stopped = 1'b1;
    fill(80, 1'b0); run_frame(80);
    rx_stopped = 1'b0;

    // random frames with the ring drained before each
    for (int k = 0; k < 20; k++) begin
      int len = $urandom_range(1, 400);
      cfg(2'd2, b_cur);
      fill(len, 1'($urandom));
      run_frame(len);
    end

    summary();
    $finish;
  end
endmodule